// File: doc/BRIEF.md
# Sparse Access-Table Memory

This block looks, from the outside, like an ordinary multi-port register file: each write port has an enable, an address and data, and each read port has an enable, an address and data out. Inside, it holds no indexed array. It holds a small table of address/value records. Every access searches the table by address. A hit reads the stored value or updates it in place. A miss claims a free record for that address.

The table is sized for the number of distinct addresses that a bounded run can touch, and not for the address space. A wide address bus therefore costs comparators, not storage. A read of an address that has never been touched returns the value on `init_i` and stores that value, so every later read of the same address agrees with the first one. Once every record is in use, an access that misses is dropped and a sticky overflow flag is raised. A synchronous clear empties the table.

Top module: `sat_mem`

## Requirements
- R1: After reset the table is empty: `full_o` and `overflow_o` are low, and a read of any address returns `init_i`.
- R2: A write makes its data visible at that address to every read that happens in a later cycle.
- R3: A read that misses returns `init_i` and stores that value; later reads of the address return the stored value even after `init_i` changes.
- R4: A write to an address that already has a record updates that record in place and uses no further record.
- R5: Read data is combinational and reflects the table as it stood at the start of the cycle; a write in the same cycle is not visible until the next cycle.
- R6: When several ports access the same unrecorded address in one cycle, only one record is allocated.
- R7: When write ports target the same address in one cycle, the lowest-numbered port's data is stored.
- R8: When a write and a read target the same unrecorded address in one cycle, the record takes the write data, and the read returns `init_i` in that cycle.
- R9: `full_o` is high exactly when all NUM_REC records are in use. Only a clear lowers it.
- R10: An access that misses while no record is free changes no record and sets `overflow_o`, which stays high until reset or clear.
- R11: `clear_i` empties every record and lowers `full_o` and `overflow_o` at the next edge.
- R12: Any address in the full ADDR_W range can be recorded; capacity depends only on NUM_REC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all records |
| we_i | input | NUM_WR | Write enable per write port |
| waddr_i | input | NUM_WR x ADDR_W | Write address per write port |
| wdata_i | input | NUM_WR x DATA_W | Write data per write port |
| re_i | input | NUM_RD | Read enable per read port |
| raddr_i | input | NUM_RD x ADDR_W | Read address per read port |
| init_i | input | DATA_W | Value returned and stored on a read miss |
| rdata_o | output | NUM_RD x DATA_W | Read data per read port |
| full_o | output | 1 | All records in use |
| overflow_o | output | 1 | Sticky flag: a miss was dropped for lack of a free record |

## Verification
The bench aims at same-cycle collisions. Two write ports on one address would store the wrong data if the priority were inverted. A read and a write on one new address would return the write data too early, or allocate two records. Two reads on one new address would use two records, and `full_o` would then rise one access early. It also changes `init_i` between reads to catch a design that re-reads the init value rather than storing it. It fills the table to catch a miss that overwrites a live record or fails to raise the overflow flag. Random traffic over a small pool of addresses spread across the full range, with occasional clears, exercises hits, fills and clears against a reference list held in the bench.

// File: rtl/sat_pkg.sv
package sat_pkg;
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sat_match.sv
module sat_match #(
  parameter int NUM_REC = 8,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_REC-1:0]             rec_valid_i,
  input  logic [NUM_REC-1:0][ADDR_W-1:0] rec_addr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_idx_o
);
  // records hold unique addresses, so at most one matches
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int r = 0; r < NUM_REC; r++) begin
      if (rec_valid_i[r] && rec_addr_i[r] == addr_i) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(r);
      end
    end
  end
endmodule

// File: rtl/sat_alloc.sv
module sat_alloc #(
  parameter int NUM_REQ = 4,
  parameter int NUM_REC = 8,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_REQ-1:0]             req_v_i,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0] req_addr_i,
  input  logic [NUM_REQ-1:0]             req_hit_i,
  input  logic [NUM_REC-1:0]             rec_valid_i,
  output logic [NUM_REQ-1:0]             new_o,
  output logic [NUM_REQ-1:0]             grant_o,
  output logic [NUM_REQ-1:0][IDX_W-1:0]  slot_o,
  output logic                           ovf_o
);
  logic [NUM_REC-1:0] free;
  logic               dup;
  logic               found;

  // request order is priority order: writes first, then reads
  always_comb begin
    free    = ~rec_valid_i;
    new_o   = '0;
    grant_o = '0;
    slot_o  = '0;
    dup     = 1'b0;
    found   = 1'b0;
    for (int q = 0; q < NUM_REQ; q++) begin
      dup = 1'b0;
      for (int p = 0; p < q; p++) begin
        if (req_v_i[p] && !req_hit_i[p] && req_addr_i[p] == req_addr_i[q]) dup = 1'b1;
      end
      new_o[q] = req_v_i[q] && !req_hit_i[q] && !dup;
      found    = 1'b0;
      if (new_o[q]) begin
        for (int r = 0; r < NUM_REC; r++) begin
          if (!found && free[r]) begin
            found     = 1'b1;
            slot_o[q] = IDX_W'(r);
          end
        end
        if (found) begin
          grant_o[q]        = 1'b1;
          free[slot_o[q]]   = 1'b0;
        end
      end
    end
    ovf_o = |(new_o & ~grant_o);
  end
endmodule

// File: rtl/sat_mem.sv
module sat_mem #(
  parameter int NUM_WR  = 2,
  parameter int NUM_RD  = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_REC = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic [NUM_WR-1:0]              we_i,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  waddr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wdata_i,
  input  logic [NUM_RD-1:0]              re_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  raddr_i,
  input  logic [DATA_W-1:0]              init_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o,
  output logic                           full_o,
  output logic                           overflow_o
);
  localparam int NUM_REQ = NUM_WR + NUM_RD;
  localparam int IDX_W   = sat_pkg::idx_width(NUM_REC);

  logic [NUM_REC-1:0]             rec_valid, valid_n;
  logic [NUM_REC-1:0][ADDR_W-1:0] rec_addr, addr_n;
  logic [NUM_REC-1:0][DATA_W-1:0] rec_data, data_n;
  logic                           ovf_n;

  logic [NUM_REQ-1:0]             req_v;
  logic [NUM_REQ-1:0][ADDR_W-1:0] req_addr;
  logic [NUM_REQ-1:0][DATA_W-1:0] req_data;
  logic [NUM_REQ-1:0]             req_hit;
  logic [NUM_REQ-1:0][IDX_W-1:0]  req_hit_idx;
  logic [NUM_REQ-1:0]             req_new;
  logic [NUM_REQ-1:0]             req_grant;
  logic [NUM_REQ-1:0][IDX_W-1:0]  req_slot;
  logic                           alloc_ovf;

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
    assign req_v[w]    = we_i[w];
    assign req_addr[w] = waddr_i[w];
    assign req_data[w] = wdata_i[w];
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
    assign req_v[NUM_WR+k]    = re_i[k];
    assign req_addr[NUM_WR+k] = raddr_i[k];
    assign req_data[NUM_WR+k] = init_i;
    assign rdata_o[k] = req_hit[NUM_WR+k] ? rec_data[req_hit_idx[NUM_WR+k]] : init_i;
  end

  for (genvar q = 0; q < NUM_REQ; q++) begin : g_match
    sat_match #(
      .NUM_REC(NUM_REC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_match (
      .rec_valid_i(rec_valid),
      .rec_addr_i (rec_addr),
      .addr_i     (req_addr[q]),
      .hit_o      (req_hit[q]),
      .hit_idx_o  (req_hit_idx[q])
    );
  end

  sat_alloc #(
    .NUM_REQ(NUM_REQ), .NUM_REC(NUM_REC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_alloc (
    .req_v_i    (req_v),
    .req_addr_i (req_addr),
    .req_hit_i  (req_hit),
    .rec_valid_i(rec_valid),
    .new_o      (req_new),
    .grant_o    (req_grant),
    .slot_o     (req_slot),
    .ovf_o      (alloc_ovf)
  );

  // walk from lowest to highest priority so the winner assigns last
  always_comb begin
    valid_n = rec_valid;
    addr_n  = rec_addr;
    data_n  = rec_data;
    for (int q = NUM_REQ - 1; q >= 0; q--) begin
      if (q < NUM_WR && req_v[q] && req_hit[q]) data_n[req_hit_idx[q]] = req_data[q];
      if (req_new[q] && req_grant[q]) begin
        valid_n[req_slot[q]] = 1'b1;
        addr_n[req_slot[q]]  = req_addr[q];
        data_n[req_slot[q]]  = req_data[q];
      end
    end
    if (clear_i) valid_n = '0;
    ovf_n = clear_i ? 1'b0 : (overflow_o | alloc_ovf);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_valid  <= '0;
      rec_addr   <= '0;
      rec_data   <= '0;
      overflow_o <= 1'b0;
    end else begin
      rec_valid  <= valid_n;
      rec_addr   <= addr_n;
      rec_data   <= data_n;
      overflow_o <= ovf_n;
    end
  end

  assign full_o = &rec_valid;
endmodule

// File: rtl/sat_mem_chk.sv
module sat_mem_chk #(
  parameter int NUM_WR  = 2,
  parameter int NUM_RD  = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_REC = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           clear_i,
  input logic [NUM_WR-1:0]              we_i,
  input logic [NUM_WR-1:0][ADDR_W-1:0]  waddr_i,
  input logic [NUM_WR-1:0][DATA_W-1:0]  wdata_i,
  input logic [NUM_RD-1:0]              re_i,
  input logic [NUM_RD-1:0][ADDR_W-1:0]  raddr_i,
  input logic [DATA_W-1:0]              init_i,
  input logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o,
  input logic                           full_o,
  input logic                           overflow_o
);
  // R2: port 0 write with a free record is seen by port 0 read next cycle
  a_r2_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i[0] && !clear_i && !full_o) |=>
      (!(re_i[0] && raddr_i[0] == $past(waddr_i[0])) || rdata_o[0] == $past(wdata_i[0])));

  // R9
  a_r9_full_only_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(clear_i));

  // R10
  a_r10_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clear_i) |=> overflow_o);

  a_r10_overflow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past((|we_i) || (|re_i)));

  // R11
  a_r11_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!full_o && !overflow_o));
endmodule

bind sat_mem sat_mem_chk #(
  .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REC(NUM_REC)
) u_chk (.*);

// File: tb/sat_mem_test.sv
module sat_mem_test;
  localparam int NW = 2, NR = 2, AW = 16, DW = 16, NREC = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0, clear_i = 1'b0;
  logic [NW-1:0] we_i = '0;
  logic [NW-1:0][AW-1:0] waddr_i = '0;
  logic [NW-1:0][DW-1:0] wdata_i = '0;
  logic [NR-1:0] re_i = '0;
  logic [NR-1:0][AW-1:0] raddr_i = '0;
  logic [DW-1:0] init_i = '0;
  logic [NR-1:0][DW-1:0] rdata_o;
  logic full_o, overflow_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] m_a [NREC];
  logic [DW-1:0] m_d [NREC];
  int  m_cnt = 0;
  bit  m_ovf = 0;

  sat_mem #(.NUM_WR(NW), .NUM_RD(NR), .ADDR_W(AW), .DATA_W(DW), .NUM_REC(NREC)) uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int find(logic [AW-1:0] a);
    for (int i = 0; i < m_cnt; i++) if (m_a[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [DW-1:0] exp_rd(int k);
    int i = find(raddr_i[k]);
    return (i >= 0) ? m_d[i] : init_i;
  endfunction

  task automatic model_update();
    logic [AW-1:0] seen [NW];
    int ns = 0;
    if (clear_i) begin m_cnt = 0; m_ovf = 0; return; end
    for (int w = 0; w < NW; w++) begin
      if (we_i[w]) begin
        int i = find(waddr_i[w]);
        bit taken = 0;
        for (int s = 0; s < ns; s++) if (seen[s] == waddr_i[w]) taken = 1;
        if (i >= 0) begin
          if (!taken) m_d[i] = wdata_i[w];
        end else if (m_cnt < NREC) begin
          m_a[m_cnt] = waddr_i[w]; m_d[m_cnt] = wdata_i[w]; m_cnt++;
        end else m_ovf = 1;
        seen[ns] = waddr_i[w]; ns++;
      end
    end
    for (int k = 0; k < NR; k++) begin
      if (re_i[k] && find(raddr_i[k]) < 0) begin
        if (m_cnt < NREC) begin
          m_a[m_cnt] = raddr_i[k]; m_d[m_cnt] = init_i; m_cnt++;
        end else m_ovf = 1;
      end
    end
  endtask

  // inputs are set after a falling edge; check reads, clock, check flags
  task automatic step(string tag);
    #2;
    for (int k = 0; k < NR; k++) if (re_i[k]) check(tag, rdata_o[k], exp_rd(k));
    @(posedge clk_i);
    model_update();
    #1;
    check({tag, " R9 full"}, full_o, (m_cnt == NREC));
    check({tag, " R10 overflow"}, overflow_o, m_ovf);
    @(negedge clk_i);
    we_i = '0; re_i = '0; clear_i = 1'b0;
  endtask

  task automatic wr(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    we_i[p] = 1'b1; waddr_i[p] = a; wdata_i[p] = d;
  endtask

  task automatic rd(int p, logic [AW-1:0] a);
    re_i[p] = 1'b1; raddr_i[p] = a;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 full after reset", full_o, 0);
    check("R1 overflow after reset", overflow_o, 0);
    init_i = 16'hAAAA; rd(0, 16'h1234); #1;
    check("R1 read of empty table", rdata_o[0], 16'hAAAA);
    step("R1");

    wr(0, 16'h0010, 16'h1111); step("R2 write");
    rd(1, 16'h0010); #1; check("R2 read back", rdata_o[1], 16'h1111); step("R2");

    wr(0, 16'h0010, 16'h2222); rd(0, 16'h0010); #1;
    check("R5 same-cycle read sees old", rdata_o[0], 16'h1111); step("R5");
    rd(0, 16'h0010); #1; check("R5 next cycle", rdata_o[0], 16'h2222); step("R5");

    init_i = 16'h5555; rd(0, 16'h0300); #1; check("R3 miss returns init", rdata_o[0], 16'h5555); step("R3");
    init_i = 16'h6666; rd(1, 16'h0300); #1; check("R3 value kept", rdata_o[1], 16'h5555); step("R3");

    wr(0, 16'h0040, 16'h0A0A); wr(1, 16'h0040, 16'h0B0B); step("R7 new");
    rd(0, 16'h0040); #1; check("R7 port0 wins new", rdata_o[0], 16'h0A0A); step("R7");
    wr(0, 16'h0010, 16'h3333); wr(1, 16'h0010, 16'h4444); step("R7 hit");
    rd(0, 16'h0010); #1; check("R7 port0 wins hit", rdata_o[0], 16'h3333); step("R7");

    wr(1, 16'h0050, 16'h7777); rd(0, 16'h0050); #1;
    check("R8 read returns init", rdata_o[0], 16'h6666); step("R8");
    rd(1, 16'h0050); #1; check("R8 record holds write", rdata_o[1], 16'h7777); step("R8");

    rd(0, 16'h0060); rd(1, 16'h0060); step("R6 two reads");
    wr(0, 16'h0010, 16'h3333); step("R4 hit");
    wr(0, 16'h0070, 16'h1212); step("R4");
    check("R6 R4 seven records not full", full_o, 0);
    rd(0, 16'hFFFF); step("R12 top address");
    check("R9 full at eight", full_o, 1);
    check("R12 no overflow", overflow_o, 0);

    wr(0, 16'h0080, 16'h9999); step("R10 write miss");
    check("R10 overflow set", overflow_o, 1);
    rd(0, 16'h0080); rd(1, 16'h0010); #1;
    check("R10 dropped write", rdata_o[0], 16'h6666);
    check("R10 live record intact", rdata_o[1], 16'h3333); step("R10");
    step("R10 idle");
    check("R10 sticky", overflow_o, 1);

    clear_i = 1'b1; step("R11 clear");
    check("R11 full cleared", full_o, 0);
    check("R11 overflow cleared", overflow_o, 0);
    init_i = 16'h0F0F; rd(0, 16'h0010); #1; check("R11 read after clear", rdata_o[0], 16'h0F0F); step("R11");

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] pool [12];
      for (int i = 0; i < 12; i++) pool[i] = AW'((i * 16'h1571) ^ (i << 12));
      clear_i = ($urandom % 64) == 0;
      init_i  = DW'($urandom);
      for (int w = 0; w < NW; w++) if ($urandom % 3 == 0) wr(w, pool[$urandom % 12], DW'($urandom));
      for (int k = 0; k < NR; k++) if ($urandom % 2 == 0) rd(k, pool[$urandom % 12]);
      step("R2 R3 R4 R6 R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule